// File: doc/BRIEF.md
# Serial Audio Word Receiver with 24-bit Normalization

This block sits at the input edge of an audio datapath. It runs on the serial bit clock. It takes one data line and a left/right framing clock, and delivers one 24-bit two's-complement sample per channel to the filter stage that follows. Every incoming word is brought to a 24-bit MSB-aligned value:
- Words shorter than 24 bits receive zero low-order bits.
- For 32-bit words, only the top 24 bits are kept.
- When 32-bit length is combined with right alignment, the word is read as 24 bits.

Two static controls set the behaviour. The word-length control chooses 16, 20, 24 or 32 bits. The format control chooses the alignment of the word inside a framing phase: MSB one bit after the framing edge, MSB on the framing edge, or LSB as the last bit before the next framing edge. Both controls are taken at each framing edge and apply to the whole phase that starts there. When a phase ends, the block raises a one-cycle strobe with the assembled sample and a channel tag.

Top module: `audio_word_rx`

## Requirements
- R1: With format 01 (left aligned), the first data bit sampled on the rising bit-clock edge where the framing clock is first seen changed is the MSB. With word length 10 (24 bits), the 24 bits starting there are output unchanged.
- R2: With format 00 (delayed), the MSB is the bit sampled one bit clock after the framing change. The bit sampled on the change itself is ignored.
- R3: With format 10 (right aligned), the last N bits sampled before the next framing change form the word, LSB last. Earlier bits in the phase are ignored.
- R4: Word length 00 means 16 bits and 01 means 20 bits. The output carries the word in its upper bits, with 8 or 4 low bits forced to zero, whatever the line carries after the word.
- R5: Word length 11 (32 bits) in delayed or left-aligned format outputs the first 24 received bits. The remaining 8 bits are discarded.
- R6: Word length 11 combined with right-aligned format is handled as a 24-bit word: only the last 24 bits before the framing change are used.
- R7: In delayed format with 24-bit length, a shorter word followed by zero bits is accepted. A 16-bit word in a phase of 24 or more bit clocks yields that word shifted up by 8.
- R8: The channel tag is 0 for a word received while the framing clock was low (left) and 1 for one received while it was high (right).
- R9: The strobe is high for exactly one cycle, in the cycle after the framing change that ends a phase is sampled. There is no strobe for the first framing change after reset.
- R10: During reset the strobe, the sample and the tag are all zero.
- R11: Format 11 behaves exactly as left-aligned format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk_i | input | 1 | Framing clock: low = left phase, high = right phase |
| sdata_i | input | 1 | Serial data, MSB first |
| wlen_i | input | 2 | Word length select: 00=16, 01=20, 10=24, 11=32 bits |
| fmt_i | input | 2 | Alignment: 00 delayed, 01 left, 10 right, 11 left |
| sample_o | output | SAMPLE_W (24) | Normalized two's-complement sample |
| valid_o | output | 1 | One-cycle strobe for a completed channel word |
| chan_o | output | 1 | Channel tag of the sample: 0 left, 1 right |

## Verification
Each format is driven with phases whose unused positions carry ones, so a design that reads the wrong window or misses the one-bit delay changes the output. Short word lengths are sent with trailing ones to show that padding really zeroes the low bits. The 32-bit cases tell truncation apart from window shifting. Right alignment with 32 bits uses a phase whose leading bits differ from the last 24, which separates the forced 24-bit reading from a 32-bit one. A short word in a long delayed-format phase, together with alternating channels and the first boundary after reset, covers acceptance of short words, the channel tag and the suppression of the first strobe.

// File: rtl/awr_pkg.sv
package awr_pkg;

  typedef enum logic [1:0] {
    FMT_DELAYED  = 2'b00,
    FMT_LEFT     = 2'b01,
    FMT_RIGHT    = 2'b10,
    FMT_LEFT_ALT = 2'b11
  } fmt_e;

  localparam logic [1:0] WL_16    = 2'b00;
  localparam logic [1:0] WL_20    = 2'b01;
  localparam logic [1:0] WL_24    = 2'b10;
  localparam logic [1:0] WL_32    = 2'b11;
  localparam logic [1:0] WL_RESET = WL_24;

  localparam int LEN_W = 6;

  // Number of bits of the incoming word that reach the output window.
  function automatic logic [LEN_W-1:0] eff_len(input logic [1:0] wl, input logic [1:0] fmt);
    logic [LEN_W-1:0] n;
    case (wl)
      WL_16:   n = 6'd16;
      WL_20:   n = 6'd20;
      WL_24:   n = 6'd24;
      default: n = (fmt == FMT_RIGHT) ? 6'd24 : 6'd32;
    endcase
    return n;
  endfunction

  // MSB arrives one bit clock after the framing change.
  function automatic logic msb_late(input logic [1:0] fmt);
    return fmt == FMT_DELAYED;
  endfunction

endpackage

// File: rtl/awr_frame_det.sv
module awr_frame_det
  import awr_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrclk_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       wlen_i,
  output logic             boundary_o,
  output logic             emit_o,
  output logic             prev_lr_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [1:0]       fmt_q_o,
  output logic [CNT_W-1:0] len_q_o
);

  localparam logic [CNT_W-1:0] IDX_MAX   = '1;
  localparam logic [CNT_W-1:0] LEN_RESET = CNT_W'(eff_len(WL_RESET, FMT_DELAYED));

  logic             seen_q, seen_d;
  logic             lr_q, lr_d;
  logic             primed_q, primed_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [1:0]       fmt_q, fmt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             boundary;

  always_comb begin
    boundary = seen_q & (lrclk_i ^ lr_q);
    seen_d   = 1'b1;
    lr_d     = lrclk_i;
    primed_d = primed_q | boundary;
    if (boundary)
      idx_d = CNT_W'(1);
    else if (idx_q == IDX_MAX)
      idx_d = idx_q;
    else
      idx_d = idx_q + 1'b1;
    fmt_d = fmt_i;
    len_d = CNT_W'(eff_len(wlen_i, fmt_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      lr_q     <= 1'b0;
      primed_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      seen_q   <= seen_d;
      lr_q     <= lr_d;
      primed_q <= primed_d;
      idx_q    <= idx_d;
    end
  end

  // Configuration is taken once per phase, at its opening boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_DELAYED;
      len_q <= LEN_RESET;
    end else if (boundary) begin
      fmt_q <= fmt_d;
      len_q <= len_d;
    end
  end

  assign boundary_o = boundary;
  assign emit_o     = boundary & primed_q;
  assign prev_lr_o  = lr_q;
  assign idx_o      = idx_q;
  assign fmt_q_o    = fmt_q;
  assign len_q_o    = len_q;

endmodule

// File: rtl/awr_msb_asm.sv
module awr_msb_asm
  import awr_pkg::*;
#(
  parameter int W     = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary_i,
  input  logic             sdata_i,
  input  logic [1:0]       fmt_new_i,
  input  logic [1:0]       fmt_q_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [W-1:0]     word_o
);

  localparam logic [CNT_W-1:0] WIN = CNT_W'(W);

  logic [W-1:0]     acc_q, acc_d;
  logic [CNT_W-1:0] delay;
  logic [CNT_W-1:0] pos;
  logic             take;
  logic             load;

  always_comb begin
    delay = CNT_W'(msb_late(fmt_q_i));
    pos   = idx_i - delay;
    take  = !boundary_i && (idx_i >= delay) && (pos < len_i) && (pos < WIN);
    load  = boundary_i | take;
    acc_d = acc_q;
    if (boundary_i) begin
      acc_d        = '0;
      acc_d[W-1]   = sdata_i & ~msb_late(fmt_new_i);
    end else if (take) begin
      for (int i = 0; i < W; i++) begin
        if (pos == CNT_W'(i)) acc_d[W-1-i] = sdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (load)
      acc_q <= acc_d;
  end

  assign word_o = acc_q;

endmodule

// File: rtl/awr_lsb_asm.sv
module awr_lsb_asm #(
  parameter int W     = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [W-1:0]     word_o
);

  localparam logic [CNT_W-1:0] WIN = CNT_W'(W);

  logic [W-1:0]     sr_q, sr_d;
  logic [CNT_W-1:0] shamt;

  always_comb begin
    sr_d  = {sr_q[W-2:0], sdata_i};
    shamt = (len_i >= WIN) ? '0 : (WIN - len_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= '0;
    else
      sr_q <= sr_d;
  end

  // Holds the bits up to the one sampled just before the current edge.
  assign word_o = sr_q << shamt;

endmodule

// File: rtl/audio_word_rx.sv
module audio_word_rx
  import awr_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lrclk_i,
  input  logic                sdata_i,
  input  logic [1:0]          wlen_i,
  input  logic [1:0]          fmt_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o,
  output logic                chan_o
);

  logic             boundary;
  logic             emit;
  logic             prev_lr;
  logic [CNT_W-1:0] bit_idx;
  logic [1:0]       cur_fmt;
  logic [CNT_W-1:0] cur_len;
  logic [SAMPLE_W-1:0] msb_word, lsb_word, word_sel;

  awr_frame_det #(.CNT_W(CNT_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .lrclk_i    (lrclk_i),
    .fmt_i      (fmt_i),
    .wlen_i     (wlen_i),
    .boundary_o (boundary),
    .emit_o     (emit),
    .prev_lr_o  (prev_lr),
    .idx_o      (bit_idx),
    .fmt_q_o    (cur_fmt),
    .len_q_o    (cur_len)
  );

  awr_msb_asm #(.W(SAMPLE_W), .CNT_W(CNT_W)) u_msb (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary),
    .sdata_i    (sdata_i),
    .fmt_new_i  (fmt_i),
    .fmt_q_i    (cur_fmt),
    .idx_i      (bit_idx),
    .len_i      (cur_len),
    .word_o     (msb_word)
  );

  awr_lsb_asm #(.W(SAMPLE_W), .CNT_W(CNT_W)) u_lsb (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdata_i (sdata_i),
    .len_i   (cur_len),
    .word_o  (lsb_word)
  );

  logic [SAMPLE_W-1:0] sample_q, sample_d;
  logic                valid_q, valid_d;
  logic                chan_q, chan_d;

  always_comb begin
    word_sel = (cur_fmt == FMT_RIGHT) ? lsb_word : msb_word;
    valid_d  = emit;
    sample_d = word_sel;
    chan_d   = prev_lr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= 1'b0;
    else
      valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      chan_q   <= 1'b0;
    end else if (emit) begin
      sample_q <= sample_d;
      chan_q   <= chan_d;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
  assign chan_o   = chan_q;

endmodule

// File: rtl/awr_checker.sv
module awr_checker #(
  parameter int W     = 24,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lrclk_i,
  input logic             valid_o,
  input logic             chan_o,
  input logic [W-1:0]     sample_o,
  input logic [CNT_W-1:0] len_q
);

  localparam logic [W-1:0] MASK16 = (W'(1) << (W - 16)) - W'(1);
  localparam logic [W-1:0] MASK20 = (W'(1) << (W - 20)) - W'(1);

  AST_STROBE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(lrclk_i) != $past(lrclk_i, 2)));  // R9

  AST_CHAN_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (chan_o == $past(lrclk_i, 2)));  // R8

  AST_PAD_SHORT16: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(len_q) == CNT_W'(16)) |-> ((sample_o & MASK16) == '0));  // R4

  AST_PAD_SHORT20: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(len_q) == CNT_W'(20)) |-> ((sample_o & MASK20) == '0));  // R4

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!valid_o && sample_o == '0 && !chan_o);  // R10
    end
  end

endmodule

bind audio_word_rx awr_checker #(.W(SAMPLE_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lrclk_i  (lrclk_i),
  .valid_o  (valid_o),
  .chan_o   (chan_o),
  .sample_o (sample_o),
  .len_q    (cur_len)
);

// File: tb/tb_audio_word_rx.sv
module tb_audio_word_rx;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        lrclk;
  logic        sdata;
  logic [1:0]  wlen;
  logic [1:0]  fmt;
  logic [23:0] sample;
  logic        valid;
  logic        chan;

  int checks = 0;
  int errors = 0;

  // Reference state: what the next strobe must carry.
  logic        pend_v = 1'b0;
  logic [23:0] pend_s = '0;
  logic        pend_c = 1'b0;
  string       pend_req = "";
  logic        seen_boundary = 1'b0;
  logic [23:0] last_s = '0;
  logic        last_c = 1'b0;
  string       last_req = "";
  logic        cur_lr = 1'b0;

  audio_word_rx dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .lrclk_i  (lrclk),
    .sdata_i  (sdata),
    .wlen_i   (wlen),
    .fmt_i    (fmt),
    .sample_o (sample),
    .valid_o  (valid),
    .chan_o   (chan)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_cycle();
    checks++;
    if (valid !== pend_v) begin
      errors++;
      $display("FAIL R9 strobe actual %0b expected %0b", valid, pend_v);
    end
    if (pend_v) begin
      checks++;
      if (sample !== pend_s) begin
        errors++;
        $display("FAIL %s sample actual %06h expected %06h", pend_req, sample, pend_s);
      end
      checks++;
      if (chan !== pend_c) begin
        errors++;
        $display("FAIL R8 channel actual %0b expected %0b", chan, pend_c);
      end
    end
    pend_v = 1'b0;
  endtask

  // One framing phase: word w is left aligned in 32 bits, txlen bits long.
  task automatic send_phase(input logic [1:0] f, input logic [1:0] wl, input int txlen,
                            input logic [31:0] w, input int plen, input logic fill,
                            input string req);
    logic [63:0] bits;
    logic [23:0] expv;
    int n;
    int d;
    bits = '0;
    for (int k = 0; k < plen; k++) begin
      bits[k] = fill;
      if (f == 2'b10) begin
        if (k >= plen - txlen) bits[k] = w[31-(k-(plen-txlen))];
      end else if (f == 2'b00) begin
        if (k >= 1 && k - 1 < txlen) bits[k] = w[31-(k-1)];
      end else begin
        if (k < txlen) bits[k] = w[31-k];
      end
    end
    for (int k = 0; k < plen; k++) begin
      @(negedge clk);
      check_cycle();
      if (k == 0) begin
        wlen     = wl;
        fmt      = f;
        pend_v   = seen_boundary;
        pend_s   = last_s;
        pend_c   = last_c;
        pend_req = last_req;
      end
      lrclk = cur_lr;
      sdata = bits[k];
    end
    n = (wl == 2'b00) ? 16 : (wl == 2'b01) ? 20 : (wl == 2'b10) ? 24 : (f == 2'b10) ? 24 : 32;
    d = (f == 2'b00) ? 1 : 0;
    expv = '0;
    if (f == 2'b10) begin
      for (int j = 0; j < n; j++) expv[23-j] = bits[plen-n+j];
    end else begin
      for (int p = 0; p < 24; p++)
        if (p < n && p + d < plen) expv[23-p] = bits[p+d];
    end
    last_s        = expv;
    last_c        = cur_lr;
    last_req      = req;
    seen_boundary = 1'b1;
    cur_lr        = ~cur_lr;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R9 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lrclk = 1'b1;
    sdata = 1'b0;
    wlen  = 2'b10;
    fmt   = 2'b00;
    repeat (3) @(negedge clk);
    checks++;
    if (valid !== 1'b0 || sample !== 24'h0 || chan !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset actual %0b/%06h/%0b expected 0/000000/0", valid, sample, chan);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_cycle();
    end

    // R1 left aligned 24-bit, R8 alternating channels, R9 first boundary silent
    send_phase(2'b01, 2'b10, 24, 32'hA5C3F100, 32, 1'b1, "R1");
    send_phase(2'b01, 2'b10, 24, 32'h5A3C0E00, 32, 1'b0, "R1");
    // R2 delayed MSB
    send_phase(2'b00, 2'b10, 24, 32'h80000100, 32, 1'b1, "R2");
    send_phase(2'b00, 2'b10, 24, 32'h7FFFFE00, 32, 1'b0, "R2");
    // R3 right aligned, leading ones ignored
    send_phase(2'b10, 2'b10, 24, 32'h12345600, 32, 1'b1, "R3");
    send_phase(2'b10, 2'b10, 24, 32'hFEDCBA00, 30, 1'b0, "R3");
    // R4 short words with trailing ones
    send_phase(2'b01, 2'b00, 16, 32'hBEEF0000, 32, 1'b1, "R4");
    send_phase(2'b00, 2'b01, 20, 32'hC0DE5000, 24, 1'b1, "R4");
    send_phase(2'b10, 2'b00, 16, 32'h9A7B0000, 32, 1'b1, "R4");
    send_phase(2'b10, 2'b01, 20, 32'h3E1F7000, 28, 1'b1, "R4");
    // R5 32-bit truncation
    send_phase(2'b01, 2'b11, 32, 32'h89ABCDEF, 32, 1'b0, "R5");
    send_phase(2'b00, 2'b11, 32, 32'hF0E1D2C3, 40, 1'b1, "R5");
    // R6 right aligned with 32-bit select reads 24 bits
    send_phase(2'b10, 2'b11, 32, 32'hFF6A5B4C, 32, 1'b1, "R6");
    send_phase(2'b10, 2'b11, 24, 32'h00C3D200, 36, 1'b1, "R6");
    // R7 short word in delayed 24-bit mode
    send_phase(2'b00, 2'b10, 16, 32'hD00D0000, 24, 1'b0, "R7");
    send_phase(2'b00, 2'b10, 16, 32'h8001_0000, 32, 1'b0, "R7");
    // R11 alternate left-aligned code
    send_phase(2'b11, 2'b10, 24, 32'h6C5D4E00, 32, 1'b1, "R11");
    send_phase(2'b11, 2'b00, 16, 32'hA1B20000, 24, 1'b1, "R11");
    // closing phase makes the last word appear
    send_phase(2'b01, 2'b10, 24, 32'h0, 4, 1'b0, "R1");
    repeat (3) begin
      @(negedge clk);
      check_cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule